// File: doc/BRIEF.md
# I2C Master Register and FIFO Front End

This block is the part of an I2C master that software talks to. A 32-bit register bus reaches eight word registers: control, status, transfer length, target address, FIFO data, clock divider, edge delays and clock-stretch limit. It holds one byte FIFO. Written bytes wait there during a write transfer, and received bytes collect there during a read transfer. A counter loaded at start tracks the bytes still to move. The status flags and one interrupt line let software feed or drain the FIFO and learn when a transfer ends.

A separate bit-level engine drives SDA and SCL. The two sides meet through a small byte handshake. The block pulses `eng_start` together with a direction flag and a repeated-start flag. The engine then pulses `eng_ack` once for each byte it moves, and reports a missing acknowledge or a stretch timeout with a pulse. On an error the block drops `eng_busy` and pulses `eng_abort`, so that the engine can finish with a NACK and a STOP. One control write with the start bit launches the whole programmed length. No per-byte command follows.

Top module: `i2cm_csr_fifo`

## Requirements
- R1: After reset, status reads 0x50 (FIFO empty, room for data), control reads 0, the divider reads 0x05DC, the delay word reads 0x00300030, the stretch limit reads 0x0040, and `irq` is low.
- R2: The word-index 4 register is the FIFO. Bytes come out in the order written. Status bit 4 is high when the FIFO is not full, bit 5 when it is not empty, bit 6 when it is empty and bit 7 when it holds 16 bytes. A write to a full FIFO drops the byte. A read of an empty FIFO returns 0 and changes nothing.
- R3: A control write with bit 4 or bit 5 set empties the FIFO. These bits read back as 0.
- R4: A control write with bit 7 (go) and bit 15 (enable) set, and a nonzero length, raises status bit 0 (busy) and pulses `eng_start` for one cycle. `eng_rnw` follows control bit 0 (1 = read). Go without enable does nothing. Control bits 0, 8, 9, 10 and 15 read back as written.
- R5: Each byte the engine acknowledges lowers the remaining count by one. In a write, the byte comes from the FIFO head. In a read, the byte goes into the FIFO. When the count reaches zero, busy falls and status bit 1 (done) rises on the same edge. A go with length 0 sets done at once, with no busy and no `eng_start`.
- R6: Status bit 2 is high during a busy write while the FIFO holds fewer than 4 bytes. Status bit 3 is high during a busy read while it holds 12 or more.
- R7: `irq` is high whenever (done and control bit 8), (bit 2 and control bit 9) or (bit 3 and control bit 10).
- R8: A missing-acknowledge pulse while busy sets status bit 8. A timeout pulse while busy sets status bit 9. Either one also sets done, drops busy and pulses `eng_abort` on the next cycle.
- R9: Status bits 1, 8 and 9 are sticky. A status write clears each one whose position holds a 1 and leaves the rest unchanged.
- R10: A go issued while busy pulses `eng_start` with `eng_rstart` high, so that the engine sends a repeated start. A go from idle leaves `eng_rstart` low.
- R11: Divider bit 0 always reads and drives as 0. The delay word drives `eng_fall_dly` from bits 31:16 and `eng_rise_dly` from bits 15:0. The stretch limit, the address and the length read back as written and drive their engine outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops the FIFO at index 4) |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from current state |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle launch pulse to the engine |
| eng_rstart | output | 1 | Launch is a repeated start |
| eng_rnw | output | 1 | Transfer direction, 1 = read |
| eng_busy | output | 1 | Transfer in progress |
| eng_abort | output | 1 | One-cycle error-abort pulse |
| eng_addr | output | 7 | Target address |
| eng_div | output | 16 | SCL divider, even |
| eng_fall_dly | output | 16 | Delay after the falling edge |
| eng_rise_dly | output | 16 | Delay after the rising edge |
| eng_stretch_lim | output | 16 | Stretch timeout, 0 disables it |
| eng_tx_data | output | 8 | FIFO head byte for a write |
| eng_tx_avail | output | 1 | Busy write with data ready |
| eng_rx_space | output | 1 | Busy read with FIFO room |
| eng_ack | input | 1 | Engine moved one byte |
| eng_rx_data | input | 8 | Received byte, valid with eng_ack |
| eng_nack | input | 1 | Target gave no acknowledge |
| eng_tmo | input | 1 | Clock-stretch timeout |

## Verification
Every stored effect of a bus write or an engine acknowledge lands on the next rising edge. Status and read data are combinational from that state, so status is correct one cycle after its cause. `eng_start` and `eng_abort` are high for exactly the cycle after the edge that caused them. The bench drives each stimulus for one edge and samples at the following falling edge. That is the first point where registered results are due, and the only point where the one-cycle pulses can be seen. Expected status words come from a bench function of busy, done, direction, FIFO level and error flags. The bench tracks that level arithmetically as it pushes and pops.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

   typedef enum logic [2:0] {
      RI_CTRL = 3'd0,
      RI_STAT = 3'd1,
      RI_LEN  = 3'd2,
      RI_TADR = 3'd3,
      RI_DATA = 3'd4,
      RI_DIV  = 3'd5,
      RI_DLY  = 3'd6,
      RI_TMO  = 3'd7
   } reg_idx_e;

   // control word bit positions
   localparam int CB_RNW   = 0;
   localparam int CB_FLSHA = 4;
   localparam int CB_FLSHB = 5;
   localparam int CB_GO    = 7;
   localparam int CB_IEDN  = 8;
   localparam int CB_IETX  = 9;
   localparam int CB_IERX  = 10;
   localparam int CB_EN    = 15;

   // status word bit positions
   localparam int SB_BUSY = 0;
   localparam int SB_DONE = 1;
   localparam int SB_TXLO = 2;
   localparam int SB_RXHI = 3;
   localparam int SB_ROOM = 4;
   localparam int SB_DATA = 5;
   localparam int SB_EMPT = 6;
   localparam int SB_FULL = 7;
   localparam int SB_NACK = 8;
   localparam int SB_TMO  = 9;

endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
   parameter int DEPTH = 16,
   parameter int W     = 8,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [W-1:0]  wdata,
   input  logic          pop,
   output logic [W-1:0]  head,
   output logic [PW:0]   level,
   output logic          empty,
   output logic          full
);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp;
   logic          push_ok, pop_ok;

   assign empty   = (level == '0);
   assign full    = (level == (PW+1)'(DEPTH));
   assign push_ok = push && !full && !flush;
   assign pop_ok  = pop && !empty && !flush;
   assign head    = mem[rp];

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[i] <= '0;
         else if (push_ok && (wp == PW'(i)))
            mem[i] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else if (flush) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (push_ok) wp <= wp + 1'b1;
         if (pop_ok)  rp <= rp + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end

endmodule

// File: rtl/i2cm_len_ctr.sv
module i2cm_len_ctr #(
   parameter int LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LEN_W-1:0] load_val,
   input  logic             dec,
   output logic [LEN_W-1:0] count,
   output logic             last
);

   assign last = (count == LEN_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (load)
         count <= load_val;
      else if (dec && (count != '0))
         count <= count - 1'b1;
   end

endmodule

// File: rtl/i2cm_irq_gen.sv
module i2cm_irq_gen #(
   parameter bit REG_OUT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic done,
   input  logic tx_low,
   input  logic rx_high,
   input  logic ie_done,
   input  logic ie_tx,
   input  logic ie_rx,
   output logic irq
);

   logic req;
   assign req = (done && ie_done) || (tx_low && ie_tx) || (rx_high && ie_rx);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= req;
      end
      assign irq = irq_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign irq = req;
   end

endmodule

// File: rtl/i2cm_csr_fifo.sv
module i2cm_csr_fifo
   import i2cm_pkg::*;
#(
   parameter int           FIFO_DEPTH = 16,
   parameter int           LEN_W      = 16,
   parameter int           TADR_W     = 7,
   parameter bit           IRQ_REG    = 1'b0,
   parameter logic [15:0]  DIV_RST    = 16'h05DC,
   parameter logic [31:0]  DLY_RST    = 32'h0030_0030,
   parameter logic [15:0]  TMO_RST    = 16'h0040
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [2:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              irq,
   output logic              eng_start,
   output logic              eng_rstart,
   output logic              eng_rnw,
   output logic              eng_busy,
   output logic              eng_abort,
   output logic [TADR_W-1:0] eng_addr,
   output logic [15:0]       eng_div,
   output logic [15:0]       eng_fall_dly,
   output logic [15:0]       eng_rise_dly,
   output logic [15:0]       eng_stretch_lim,
   output logic [7:0]        eng_tx_data,
   output logic              eng_tx_avail,
   output logic              eng_rx_space,
   input  logic              eng_ack,
   input  logic [7:0]        eng_rx_data,
   input  logic              eng_nack,
   input  logic              eng_tmo
);

   localparam int PW      = $clog2(FIFO_DEPTH);
   localparam int TX_LIM  = FIFO_DEPTH / 4;
   localparam int RX_LIM  = FIFO_DEPTH - FIFO_DEPTH / 4;

   if (FIFO_DEPTH < 4 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two of at least 4");
   end
   if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
      $error("LEN_W must lie in 1..16");
   end
   if (TADR_W < 1 || TADR_W > 16) begin : g_bad_tadr
      $error("TADR_W must lie in 1..16");
   end

   // register file
   logic              rnw_q, ie_done_q, ie_tx_q, ie_rx_q, en_q;
   logic [LEN_W-1:0]  len_q;
   logic [TADR_W-1:0] tadr_q;
   logic [15:0]       div_q;
   logic [31:0]       dly_q;
   logic [15:0]       tmo_q;

   // transfer state
   logic busy_q, done_q, nack_q, tmo_flag_q;
   logic start_q, rstart_q, abort_q;

   logic wr_ctrl, wr_stat, wr_data, rd_data;
   logic go, go_run, flush, err_evt, acc, fin;
   logic fifo_push, fifo_pop;
   logic [7:0] fifo_wdata, fifo_head;
   logic [PW:0] fifo_level;
   logic fifo_empty, fifo_full;
   logic [LEN_W-1:0] remain;
   logic remain_last;
   logic tx_low, rx_high;

   assign wr_ctrl = bus_wr && (bus_addr == RI_CTRL);
   assign wr_stat = bus_wr && (bus_addr == RI_STAT);
   assign wr_data = bus_wr && (bus_addr == RI_DATA);
   assign rd_data = bus_rd && (bus_addr == RI_DATA);

   assign go      = wr_ctrl && bus_wdata[CB_GO] && bus_wdata[CB_EN];
   assign go_run  = go && (len_q != '0);
   assign flush   = wr_ctrl && (bus_wdata[CB_FLSHA] || bus_wdata[CB_FLSHB]);
   assign err_evt = busy_q && (eng_nack || eng_tmo);
   assign acc     = eng_ack && busy_q && (rnw_q ? !fifo_full : !fifo_empty);
   assign fin     = acc && remain_last;

   // engine has priority on both FIFO ports
   assign fifo_push  = (acc && rnw_q) || wr_data;
   assign fifo_wdata = (acc && rnw_q) ? eng_rx_data : bus_wdata[7:0];
   assign fifo_pop   = (acc && !rnw_q) || rd_data;

   i2cm_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (flush),
      .push  (fifo_push),
      .wdata (fifo_wdata),
      .pop   (fifo_pop),
      .head  (fifo_head),
      .level (fifo_level),
      .empty (fifo_empty),
      .full  (fifo_full)
   );

   i2cm_len_ctr #(.LEN_W(LEN_W)) u_len (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (go),
      .load_val (len_q),
      .dec      (acc),
      .count    (remain),
      .last     (remain_last)
   );

   assign tx_low  = busy_q && !rnw_q && (fifo_level < (PW+1)'(TX_LIM));
   assign rx_high = busy_q &&  rnw_q && (fifo_level >= (PW+1)'(RX_LIM));

   i2cm_irq_gen #(.REG_OUT(IRQ_REG)) u_irq (
      .clk     (clk),
      .rst_n   (rst_n),
      .done    (done_q),
      .tx_low  (tx_low),
      .rx_high (rx_high),
      .ie_done (ie_done_q),
      .ie_tx   (ie_tx_q),
      .ie_rx   (ie_rx_q),
      .irq     (irq)
   );

   // configuration registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rnw_q     <= 1'b0;
         ie_done_q <= 1'b0;
         ie_tx_q   <= 1'b0;
         ie_rx_q   <= 1'b0;
         en_q      <= 1'b0;
         len_q     <= '0;
         tadr_q    <= '0;
         div_q     <= {DIV_RST[15:1], 1'b0};
         dly_q     <= DLY_RST;
         tmo_q     <= TMO_RST;
      end else if (bus_wr) begin
         case (bus_addr)
            RI_CTRL: begin
               rnw_q     <= bus_wdata[CB_RNW];
               ie_done_q <= bus_wdata[CB_IEDN];
               ie_tx_q   <= bus_wdata[CB_IETX];
               ie_rx_q   <= bus_wdata[CB_IERX];
               en_q      <= bus_wdata[CB_EN];
            end
            RI_LEN:  len_q  <= bus_wdata[LEN_W-1:0];
            RI_TADR: tadr_q <= bus_wdata[TADR_W-1:0];
            RI_DIV:  div_q  <= {bus_wdata[15:1], 1'b0};
            RI_DLY:  dly_q  <= bus_wdata;
            RI_TMO:  tmo_q  <= bus_wdata[15:0];
            default: ;
         endcase
      end
   end

   // transfer state and sticky flags
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q     <= 1'b0;
         done_q     <= 1'b0;
         nack_q     <= 1'b0;
         tmo_flag_q <= 1'b0;
         start_q    <= 1'b0;
         rstart_q   <= 1'b0;
         abort_q    <= 1'b0;
      end else begin
         start_q  <= go_run;
         rstart_q <= go_run && busy_q;
         abort_q  <= err_evt && !go;

         if (go)           busy_q <= go_run;
         else if (err_evt) busy_q <= 1'b0;
         else if (fin)     busy_q <= 1'b0;

         if ((go && !go_run) || fin || err_evt)
            done_q <= 1'b1;
         else if (wr_stat && bus_wdata[SB_DONE])
            done_q <= 1'b0;

         if (busy_q && eng_nack)
            nack_q <= 1'b1;
         else if (wr_stat && bus_wdata[SB_NACK])
            nack_q <= 1'b0;

         if (busy_q && eng_tmo)
            tmo_flag_q <= 1'b1;
         else if (wr_stat && bus_wdata[SB_TMO])
            tmo_flag_q <= 1'b0;
      end
   end

   // read mux
   logic [31:0] ctrl_word, stat_word;

   always_comb begin
      ctrl_word            = '0;
      ctrl_word[CB_RNW]    = rnw_q;
      ctrl_word[CB_IEDN]   = ie_done_q;
      ctrl_word[CB_IETX]   = ie_tx_q;
      ctrl_word[CB_IERX]   = ie_rx_q;
      ctrl_word[CB_EN]     = en_q;

      stat_word            = '0;
      stat_word[SB_BUSY]   = busy_q;
      stat_word[SB_DONE]   = done_q;
      stat_word[SB_TXLO]   = tx_low;
      stat_word[SB_RXHI]   = rx_high;
      stat_word[SB_ROOM]   = !fifo_full;
      stat_word[SB_DATA]   = !fifo_empty;
      stat_word[SB_EMPT]   = fifo_empty;
      stat_word[SB_FULL]   = fifo_full;
      stat_word[SB_NACK]   = nack_q;
      stat_word[SB_TMO]    = tmo_flag_q;
   end

   always_comb begin
      case (bus_addr)
         RI_CTRL: bus_rdata = ctrl_word;
         RI_STAT: bus_rdata = stat_word;
         RI_LEN:  bus_rdata = 32'(len_q);
         RI_TADR: bus_rdata = 32'(tadr_q);
         RI_DATA: bus_rdata = fifo_empty ? 32'h0 : {24'h0, fifo_head};
         RI_DIV:  bus_rdata = {16'h0, div_q};
         RI_DLY:  bus_rdata = dly_q;
         default: bus_rdata = {16'h0, tmo_q};
      endcase
   end

   // engine side
   assign eng_start       = start_q;
   assign eng_rstart      = rstart_q;
   assign eng_rnw         = rnw_q;
   assign eng_busy        = busy_q;
   assign eng_abort       = abort_q;
   assign eng_addr        = tadr_q;
   assign eng_div         = div_q;
   assign eng_fall_dly    = dly_q[31:16];
   assign eng_rise_dly    = dly_q[15:0];
   assign eng_stretch_lim = tmo_q;
   assign eng_tx_data     = fifo_head;
   assign eng_tx_avail    = busy_q && !rnw_q && !fifo_empty;
   assign eng_rx_space    = busy_q && rnw_q && !fifo_full;

   logic unused_bits;
   assign unused_bits = ^remain;

endmodule

// File: rtl/i2cm_csr_fifo_chk.sv
module i2cm_csr_fifo_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        bus_wr,
   input logic        bus_rd,
   input logic [2:0]  bus_addr,
   input logic [31:0] bus_wdata,
   input logic [31:0] bus_rdata,
   input logic        irq,
   input logic        eng_start,
   input logic        eng_busy,
   input logic        eng_abort,
   input logic        eng_nack,
   input logic        eng_tmo,
   input logic        done_q,
   input logic        nack_q,
   input logic        ie_done_q,
   input logic        fifo_empty,
   input logic        fifo_full
);

   // R2
   flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(fifo_empty && fifo_full));

   // R2
   empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == 3'd4 && fifo_empty) |-> (bus_rdata == 32'h0));

   // R4
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |-> eng_busy);

   // R8
   err_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_busy && (eng_nack || eng_tmo) && !(bus_wr && bus_addr == 3'd0 && bus_wdata[7]))
      |=> (eng_abort && !eng_busy && done_q));

   // R8
   nack_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(nack_q) |-> done_q);

   // R9
   done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && !(bus_wr && bus_addr == 3'd1 && bus_wdata[1])) |=> done_q);

   // R7
   irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_q && ie_done_q) |-> irq);

endmodule

bind i2cm_csr_fifo i2cm_csr_fifo_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_rd     (bus_rd),
   .bus_addr   (bus_addr),
   .bus_wdata  (bus_wdata),
   .bus_rdata  (bus_rdata),
   .irq        (irq),
   .eng_start  (eng_start),
   .eng_busy   (eng_busy),
   .eng_abort  (eng_abort),
   .eng_nack   (eng_nack),
   .eng_tmo    (eng_tmo),
   .done_q     (done_q),
   .nack_q     (nack_q),
   .ie_done_q  (ie_done_q),
   .fifo_empty (fifo_empty),
   .fifo_full  (fifo_full)
);

// File: tb/sim_i2cm_csr_fifo.sv
module sim_i2cm_csr_fifo;

   localparam int CLK_PERIOD = 10;
   localparam int DEPTH      = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq, eng_start, eng_rstart, eng_rnw, eng_busy, eng_abort;
   logic [6:0]  eng_addr;
   logic [15:0] eng_div, eng_fall_dly, eng_rise_dly, eng_stretch_lim;
   logic [7:0]  eng_tx_data;
   logic        eng_tx_avail, eng_rx_space;
   logic        eng_ack = 1'b0, eng_nack = 1'b0, eng_tmo = 1'b0;
   logic [7:0]  eng_rx_data = '0;

   int vectors = 0;
   int misses  = 0;
   int level   = 0;
   bit ended   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2cm_csr_fifo u0 (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .eng_start(eng_start), .eng_rstart(eng_rstart),
      .eng_rnw(eng_rnw), .eng_busy(eng_busy), .eng_abort(eng_abort),
      .eng_addr(eng_addr), .eng_div(eng_div), .eng_fall_dly(eng_fall_dly),
      .eng_rise_dly(eng_rise_dly), .eng_stretch_lim(eng_stretch_lim),
      .eng_tx_data(eng_tx_data), .eng_tx_avail(eng_tx_avail),
      .eng_rx_space(eng_rx_space), .eng_ack(eng_ack),
      .eng_rx_data(eng_rx_data), .eng_nack(eng_nack), .eng_tmo(eng_tmo)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] st(input bit busy, input bit done, input bit rnw,
                                      input int lvl, input bit nk, input bit to);
      logic [31:0] s = '0;
      s[0] = busy;
      s[1] = done;
      s[2] = busy && !rnw && (lvl < DEPTH/4);
      s[3] = busy && rnw && (lvl >= DEPTH - DEPTH/4);
      s[4] = (lvl < DEPTH);
      s[5] = (lvl > 0);
      s[6] = (lvl == 0);
      s[7] = (lvl == DEPTH);
      s[8] = nk;
      s[9] = to;
      return s;
   endfunction

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pop(output logic [31:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = 3'd4;
      #1;
      d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic ack(input logic [7:0] b);
      @(negedge clk);
      eng_ack = 1'b1; eng_rx_data = b;
      @(negedge clk);
      eng_ack = 1'b0;
   endtask

   task automatic stat_is(input string req, input logic [31:0] exp);
      logic [31:0] v;
      rd(3'd1, v);
      chk(req, v, exp);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!ended) begin
         misses++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      stat_is("R1 status", 32'h50);
      rd(3'd0, v); chk("R1 ctrl", v, 0);
      rd(3'd5, v); chk("R1 div", v, 32'h05DC);
      rd(3'd6, v); chk("R1 dly", v, 32'h0030_0030);
      rd(3'd7, v); chk("R1 tmo", v, 32'h40);
      chk("R1 irq", 32'(irq), 0);

      // R2 fill sweep with flag check at every level
      for (int k = 1; k <= DEPTH; k++) begin
         wr(3'd4, 32'((k * 7 + 3) & 8'hFF));
         level = k;
         stat_is("R2 fill flags", st(0, 0, 0, level, 0, 0));
      end
      wr(3'd4, 32'hEE);
      stat_is("R2 full drop flags", st(0, 0, 0, DEPTH, 0, 0));
      for (int k = 1; k <= DEPTH; k++) begin
         pop(v);
         chk("R2 order", v, 32'((k * 7 + 3) & 8'hFF));
         level = DEPTH - k;
         stat_is("R2 drain flags", st(0, 0, 0, level, 0, 0));
      end
      pop(v);
      chk("R2 empty read", v, 0);
      stat_is("R2 empty unchanged", 32'h50);

      // R3 flush via either bit
      for (int b = 4; b <= 5; b++) begin
         wr(3'd4, 32'h11); wr(3'd4, 32'h22); wr(3'd4, 32'h33);
         stat_is("R3 pre flush", st(0, 0, 0, 3, 0, 0));
         wr(3'd0, 32'(1) << b);
         stat_is("R3 flushed", 32'h50);
         rd(3'd0, v); chk("R3 reads zero", v, 0);
      end

      // R4 readback and go without enable
      wr(3'd0, 32'h0701);
      rd(3'd0, v); chk("R4 ctrl readback", v, 32'h0701);
      wr(3'd2, 32'd3);
      wr(3'd0, 32'h0080);
      chk("R4 no start w/o enable", 32'(eng_start), 0);
      stat_is("R4 idle w/o enable", 32'h50);

      // R5 R6 R7 R9 write transfers of several lengths
      wr(3'd3, 32'h2A);
      for (int n = 1; n <= 6; n++) begin
         wr(3'd2, 32'(n));
         for (int i = 0; i < n; i++) wr(3'd4, 32'(8'h40 + n * 8 + i));
         level = n;
         wr(3'd0, 32'h8180);
         chk("R4 start pulse", 32'(eng_start), 1);
         chk("R10 no restart from idle", 32'(eng_rstart), 0);
         chk("R4 rnw write", 32'(eng_rnw), 0);
         chk("R11 addr out", 32'(eng_addr), 32'h2A);
         stat_is("R6 write start flags", st(1, 0, 0, level, 0, 0));
         for (int i = 0; i < n; i++) begin
            chk("R5 tx head", 32'(eng_tx_data), 32'(8'h40 + n * 8 + i));
            ack(8'h00);
            level--;
            stat_is("R5 write progress", st(i != n - 1, i == n - 1, 0, level, 0, 0));
         end
         chk("R7 done irq", 32'(irq), 1);
         wr(3'd1, 32'h2);
         stat_is("R9 done cleared", 32'h50);
         chk("R7 irq cleared", 32'(irq), 0);
      end

      // R6 R7 transmit-low interrupt, then R8 nack abort
      wr(3'd2, 32'd8);
      wr(3'd4, 32'hA1); wr(3'd4, 32'hA2);
      wr(3'd0, 32'h8280);
      stat_is("R6 tx low", st(1, 0, 0, 2, 0, 0));
      chk("R7 tx irq", 32'(irq), 1);
      for (int i = 0; i < 4; i++) wr(3'd4, 32'(8'hB0 + i));
      stat_is("R6 tx not low", st(1, 0, 0, 6, 0, 0));
      chk("R7 tx irq off", 32'(irq), 0);
      @(negedge clk); eng_nack = 1'b1;
      @(negedge clk); eng_nack = 1'b0;
      chk("R8 abort pulse", 32'(eng_abort), 1);
      stat_is("R8 nack status", st(0, 1, 0, 6, 1, 0));
      wr(3'd1, 32'h100);
      stat_is("R9 nack only cleared", st(0, 1, 0, 6, 0, 0));
      wr(3'd1, 32'h2);
      wr(3'd0, 32'h10);
      stat_is("R3 flush after abort", 32'h50);

      // R5 R6 R7 read transfer
      wr(3'd2, 32'd16);
      wr(3'd0, 32'h8481);
      chk("R4 rnw read", 32'(eng_rnw), 1);
      level = 0;
      for (int i = 0; i < 12; i++) begin
         ack(8'h80 + 8'(i));
         level++;
         stat_is("R6 rx level", st(1, 0, 1, level, 0, 0));
         chk("R7 rx irq", 32'(irq), 32'(level >= 12));
      end
      for (int i = 0; i < 12; i++) begin
         pop(v);
         chk("R5 rx order", v, 32'(8'h80 + i));
      end
      level = 0;
      for (int i = 12; i < 16; i++) begin
         ack(8'h80 + 8'(i));
         level++;
      end
      stat_is("R5 read done", st(0, 1, 1, 4, 0, 0));
      for (int i = 12; i < 16; i++) begin
         pop(v);
         chk("R5 rx tail", v, 32'(8'h80 + i));
      end
      wr(3'd1, 32'h2);

      // R10 repeated start, then R8 timeout
      wr(3'd2, 32'd2);
      wr(3'd4, 32'h01); wr(3'd4, 32'h02);
      wr(3'd0, 32'h8080);
      wr(3'd0, 32'h8081);
      chk("R10 restart start", 32'(eng_start), 1);
      chk("R10 restart flag", 32'(eng_rstart), 1);
      chk("R10 restart rnw", 32'(eng_rnw), 1);
      @(negedge clk); eng_tmo = 1'b1;
      @(negedge clk); eng_tmo = 1'b0;
      chk("R8 tmo abort", 32'(eng_abort), 1);
      stat_is("R8 tmo status", st(0, 1, 1, 2, 0, 1));
      wr(3'd1, 32'h202);
      wr(3'd0, 32'h20);
      stat_is("R9 tmo cleared", 32'h50);

      // R5 zero length
      wr(3'd2, 32'd0);
      wr(3'd0, 32'h8080);
      chk("R5 zero len no start", 32'(eng_start), 0);
      stat_is("R5 zero len done", st(0, 1, 0, 0, 0, 0));
      wr(3'd1, 32'h2);

      // R11 timing registers
      wr(3'd5, 32'h0007);
      rd(3'd5, v); chk("R11 div read even", v, 32'h6);
      chk("R11 div out", 32'(eng_div), 32'h6);
      wr(3'd6, 32'h0005_0009);
      chk("R11 fall dly", 32'(eng_fall_dly), 32'h5);
      chk("R11 rise dly", 32'(eng_rise_dly), 32'h9);
      wr(3'd7, 32'h1234);
      chk("R11 stretch", 32'(eng_stretch_lim), 32'h1234);
      rd(3'd2, v); chk("R11 len read", v, 0);

      ended = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end

endmodule